// File: doc/BRIEF.md
# Banked and Indirect Data Address Unit

This unit forms the 12-bit data memory address for every data access of a small 8-bit controller core. The address comes from one of two paths. The direct path takes an 8-bit file operand. When the access-select bit is set, the operand is mapped into a fixed window. That window joins the bottom half-page of RAM with the top half-page of special registers. When the access-select bit is clear, the operand is joined to a 4-bit bank register.

Three 12-bit pointers give indirect access. Each pointer owns five virtual register addresses. A direct access to one of these addresses is redirected to the location the pointer selects. The virtual address used also decides whether the pointer steps before or after the access, or is offset by the signed W value. The pointer halves also appear as readable and writable special registers, and a load operation can set a whole pointer from a 12-bit literal.

Everything outside address forming stays with the core: the RAM array, the ALU and instruction decode. The resolved address is combinational from the current inputs. Pointer side effects take place on the clock edge that ends the strobed access.

Top module: `data_addr_unit`

## Requirements
- R1: After reset all three pointers read 0x000 and the bank register is 0x0, so an unbanked access to operand 0x34 resolves to 0x034.
- R2: With the access bit set, operands 0x00-0x7F resolve to 0x000-0x07F and operands 0x80-0xFF resolve to 0xF80-0xFFF.
- R3: With the access bit clear, the address is {bank, operand}; the bank register takes bsel_d_i on a clock edge with bsel_we_i high.
- R4: Pointer k (k = 0, 1, 2) has its plain virtual register at 0xFEF - 8k. The other virtual registers sit just below it: -1 post-increment, -2 post-decrement, -3 pre-increment, -4 plus-W. A plain access resolves to the pointer value and leaves the pointer unchanged.
- R5: A post-increment or post-decrement access resolves to the current pointer value. The pointer then changes by one at the closing edge, wrapping modulo 4096.
- R6: A pre-increment access resolves to pointer + 1, and the pointer holds that value after the edge.
- R7: A plus-W access resolves to the pointer plus W, with W taken as a signed 8-bit value, modulo 4096. The pointer is left unchanged.
- R8: A load sets pointer ldptr_sel_i to ldptr_val_i at the next edge. A load takes priority over any access side effect on the same pointer in the same cycle.
- R9: Pointer k's high half is at 0xFEA - 8k and its low half at 0xFE9 - 8k. A direct access to either raises sfr_hit_o and returns the half on sfr_rdata_o; for the high half, address bits 11:8 appear in data bits 3:0 with the upper data bits zero. A strobed write stores wdata_i into that half; a high-half write keeps bits 3:0 only.
- R10: Pointers change only at an edge with acc_i or ldptr_i high. A virtual or half address with the strobe low has no effect.
- R11: A pointer-derived address that itself falls on any virtual register raises null_o: the read data counts as 0x00 and the write is dropped by the memory side. The address is still driven, and the pointer side effect of the access still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_i | input | 1 | Access strobe, one cycle per data access |
| wr_i | input | 1 | Access is a write |
| oper_i | input | 8 | File operand |
| abank_i | input | 1 | Access-select: 1 fixed window, 0 bank register |
| w_i | input | 8 | W register value (signed offset) |
| wdata_i | input | 8 | Write data for pointer halves |
| bsel_we_i | input | 1 | Bank register write enable |
| bsel_d_i | input | 4 | Bank register new value |
| ldptr_i | input | 1 | Load whole pointer |
| ldptr_sel_i | input | 2 | Pointer to load |
| ldptr_val_i | input | 12 | Literal to load |
| addr_o | output | 12 | Resolved data address |
| null_o | output | 1 | Nested virtual access: read zero, drop write |
| sfr_hit_o | output | 1 | Access targets a pointer half |
| sfr_rdata_o | output | 8 | Pointer half read data |
| ptr_o | output | 36 | Pointer contents, pointer k in bits 12k+11:12k |

## Verification
The assertions check on every cycle that the pointers hold still without a strobe or a load. They also check the low fixed-window mapping, the post-increment and pre-increment steps of pointer 0, load priority, and that null_o only flags addresses inside a virtual window. Banked mapping, signed W offsets with wraparound, the post-decrement and wraparound cases on the other pointers, the half-register reads and writes, and the nested-redirect side effect are shown only by the bench scenarios. The bench compares them against its own pointer model.

// File: rtl/dau_pkg.sv
package dau_pkg;

   typedef enum logic [2:0] {
      VM_PLAIN   = 3'd0,
      VM_POSTINC = 3'd1,
      VM_POSTDEC = 3'd2,
      VM_PREINC  = 3'd3,
      VM_PLUSW   = 3'd4
   } vmode_t;

   // offsets below a pointer's plain virtual register
   localparam int HI_OFS    = 5;
   localparam int LO_OFS    = 6;
   localparam int VREG_SPAN = 5;

   function automatic logic is_vreg(input int a, input int top, input int stride, input int n);
      logic r;
      r = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (a <= top - i*stride && a >= top - i*stride - (VREG_SPAN-1)) r = 1'b1;
      end
      return r;
   endfunction

endpackage

// File: rtl/dau_direct.sv
module dau_direct #(
   parameter int AW = 12
) (
   input  logic [7:0]    oper_i,
   input  logic          abank_i,
   input  logic [AW-9:0] bank_i,
   output logic [AW-1:0] daddr_o
);
   always_comb begin
      if (abank_i)
         daddr_o = {{(AW-8){oper_i[7]}}, oper_i};
      else
         daddr_o = {bank_i, oper_i};
   end
endmodule

// File: rtl/dau_ptr.sv
module dau_ptr
   import dau_pkg::*;
#(
   parameter int AW    = 12,
   parameter int VBASE = 'hFEF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] daddr_i,
   input  logic          acc_i,
   input  logic          wr_i,
   input  logic [7:0]    wdata_i,
   input  logic [7:0]    w_i,
   input  logic          ld_i,
   input  logic [AW-1:0] ld_val_i,
   output logic          vhit_o,
   output logic [AW-1:0] eaddr_o,
   output logic          hhit_o,
   output logic [7:0]    hrd_o,
   output logic [AW-1:0] ptr_o
);
   localparam logic [AW-1:0] V_TOP = AW'(VBASE);
   localparam logic [AW-1:0] V_BOT = AW'(VBASE - (VREG_SPAN-1));
   localparam logic [AW-1:0] A_HI  = AW'(VBASE - HI_OFS);
   localparam logic [AW-1:0] A_LO  = AW'(VBASE - LO_OFS);
   localparam logic [AW-1:0] ONE   = AW'(1);

   logic [AW-1:0] ptr_q, ptr_d, w_sx;
   logic          hi_hit, lo_hit;
   vmode_t        mode;
   wire           unused_wd = &{1'b0, wdata_i[7:AW-8]};

   assign vhit_o = (daddr_i <= V_TOP) && (daddr_i >= V_BOT);
   assign mode   = vmode_t'(V_TOP[2:0] - daddr_i[2:0]);
   assign hi_hit = (daddr_i == A_HI);
   assign lo_hit = (daddr_i == A_LO);
   assign hhit_o = hi_hit | lo_hit;
   assign w_sx   = {{(AW-8){w_i[7]}}, w_i};
   assign ptr_o  = ptr_q;

   always_comb begin
      case (mode)
         VM_PREINC: eaddr_o = ptr_q + ONE;
         VM_PLUSW:  eaddr_o = ptr_q + w_sx;
         default:   eaddr_o = ptr_q;
      endcase
   end

   always_comb begin
      hrd_o = '0;
      if (hi_hit)      hrd_o[AW-9:0] = ptr_q[AW-1:8];
      else if (lo_hit) hrd_o = ptr_q[7:0];
   end

   always_comb begin
      ptr_d = ptr_q;
      if (acc_i && vhit_o) begin
         case (mode)
            VM_POSTINC, VM_PREINC: ptr_d = ptr_q + ONE;
            VM_POSTDEC:            ptr_d = ptr_q - ONE;
            default:               ptr_d = ptr_q;
         endcase
      end else if (acc_i && wr_i && hi_hit) begin
         ptr_d = {wdata_i[AW-9:0], ptr_q[7:0]};
      end else if (acc_i && wr_i && lo_hit) begin
         ptr_d = {ptr_q[AW-1:8], wdata_i};
      end
      if (ld_i) ptr_d = ld_val_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end
endmodule

// File: rtl/data_addr_unit.sv
module data_addr_unit
   import dau_pkg::*;
#(
   parameter int AW      = 12,
   parameter int NPTR    = 3,
   parameter int VTOP    = 'hFEF,
   parameter int VSTRIDE = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc_i,
   input  logic                   wr_i,
   input  logic [7:0]             oper_i,
   input  logic                   abank_i,
   input  logic [7:0]             w_i,
   input  logic [7:0]             wdata_i,
   input  logic                   bsel_we_i,
   input  logic [AW-9:0]          bsel_d_i,
   input  logic                   ldptr_i,
   input  logic [$clog2(NPTR)-1:0] ldptr_sel_i,
   input  logic [AW-1:0]          ldptr_val_i,
   output logic [AW-1:0]          addr_o,
   output logic                   null_o,
   output logic                   sfr_hit_o,
   output logic [7:0]             sfr_rdata_o,
   output logic [NPTR*AW-1:0]     ptr_o
);
   localparam int BW     = AW - 8;
   localparam int LOWEST = VTOP - (NPTR-1)*VSTRIDE - LO_OFS;

   if (AW < 9 || AW > 15) begin : g_bad_aw
      $error("data_addr_unit: AW must lie in 9..15");
   end
   if (NPTR < 2) begin : g_bad_nptr
      $error("data_addr_unit: NPTR must be at least 2");
   end
   if (VSTRIDE < LO_OFS + 1) begin : g_bad_stride
      $error("data_addr_unit: VSTRIDE too small for one pointer's registers");
   end
   if (VTOP >= 2**AW || LOWEST < 0) begin : g_bad_vtop
      $error("data_addr_unit: virtual registers fall outside the address space");
   end

   logic [BW-1:0] bank_q;
   logic [AW-1:0] daddr;
   logic [NPTR-1:0] vhit, hhit;
   logic [AW-1:0] eaddr [NPTR];
   logic [7:0]    hrd   [NPTR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bank_q <= '0;
      else if (bsel_we_i) bank_q <= bsel_d_i;
   end

   dau_direct #(.AW(AW)) i_direct (
      .oper_i  (oper_i),
      .abank_i (abank_i),
      .bank_i  (bank_q),
      .daddr_o (daddr)
   );

   for (genvar k = 0; k < NPTR; k++) begin : g_ptr
      dau_ptr #(.AW(AW), .VBASE(VTOP - k*VSTRIDE)) i_ptr (
         .clk      (clk),
         .rst_n    (rst_n),
         .daddr_i  (daddr),
         .acc_i    (acc_i),
         .wr_i     (wr_i),
         .wdata_i  (wdata_i),
         .w_i      (w_i),
         .ld_i     (ldptr_i && (int'(ldptr_sel_i) == k)),
         .ld_val_i (ldptr_val_i),
         .vhit_o   (vhit[k]),
         .eaddr_o  (eaddr[k]),
         .hhit_o   (hhit[k]),
         .hrd_o    (hrd[k]),
         .ptr_o    (ptr_o[k*AW +: AW])
      );
   end

   always_comb begin
      addr_o      = daddr;
      sfr_rdata_o = '0;
      for (int k = 0; k < NPTR; k++) begin
         if (vhit[k]) addr_o = eaddr[k];
         sfr_rdata_o = sfr_rdata_o | hrd[k];
      end
   end

   assign sfr_hit_o = |hhit;
   assign null_o    = (|vhit) && is_vreg(int'(addr_o), VTOP, VSTRIDE, NPTR);
endmodule

// File: rtl/dau_chk.sv
module dau_chk
   import dau_pkg::*;
#(
   parameter int AW      = 12,
   parameter int NPTR    = 3,
   parameter int VTOP    = 'hFEF,
   parameter int VSTRIDE = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    acc_i,
   input logic                    abank_i,
   input logic [7:0]              oper_i,
   input logic                    ldptr_i,
   input logic [$clog2(NPTR)-1:0] ldptr_sel_i,
   input logic [AW-1:0]           ldptr_val_i,
   input logic [AW-1:0]           addr_o,
   input logic                    null_o,
   input logic [NPTR*AW-1:0]      ptr_o
);
   localparam logic [AW-1:0] A_PINC0 = AW'(VTOP - 1);
   localparam logic [AW-1:0] A_PRE0  = AW'(VTOP - 3);
   localparam logic [AW-1:0] ONE     = AW'(1);

   logic [AW-1:0] win_addr;
   logic [AW-1:0] ptr0;
   assign win_addr = {{(AW-8){1'b1}}, oper_i};
   assign ptr0     = ptr_o[AW-1:0];

   // R10
   stable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_i && !ldptr_i) |=> $stable(ptr_o));

   // R2
   low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abank_i && !oper_i[7]) |-> (addr_o == {{(AW-8){1'b0}}, oper_i} && !null_o));

   // R5
   postinc0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i && !ldptr_i && abank_i && oper_i[7] && win_addr == A_PINC0)
      |-> (addr_o == ptr0) ##1 (ptr0 == $past(ptr0) + ONE));

   // R6
   preinc0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i && !ldptr_i && abank_i && oper_i[7] && win_addr == A_PRE0)
      |=> (ptr0 == $past(addr_o)));

   // R8
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ldptr_i && int'(ldptr_sel_i) < NPTR)
      |=> (ptr_o[int'($past(ldptr_sel_i))*AW +: AW] == $past(ldptr_val_i)));

   // R11
   null_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      null_o |-> is_vreg(int'(addr_o), VTOP, VSTRIDE, NPTR));
endmodule

bind data_addr_unit dau_chk #(.AW(AW), .NPTR(NPTR), .VTOP(VTOP), .VSTRIDE(VSTRIDE)) i_dau_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_i       (acc_i),
   .abank_i     (abank_i),
   .oper_i      (oper_i),
   .ldptr_i     (ldptr_i),
   .ldptr_sel_i (ldptr_sel_i),
   .ldptr_val_i (ldptr_val_i),
   .addr_o      (addr_o),
   .null_o      (null_o),
   .ptr_o       (ptr_o)
);

// File: tb/test_data_addr_unit.sv
module test_data_addr_unit;
   localparam int CLK_P = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        acc = 1'b0, wr_s = 1'b0, abank = 1'b0, bwe = 1'b0, ldp = 1'b0;
   logic [7:0]  oper = '0, wv = '0, wdata = '0;
   logic [3:0]  bsel = '0;
   logic [1:0]  lsel = '0;
   logic [11:0] lval = '0;
   logic [11:0] addr_o;
   logic        null_o, sfr_hit_o;
   logic [7:0]  sfr_rdata_o;
   logic [35:0] ptr_o;

   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   data_addr_unit i_data_addr_unit (
      .clk(clk), .rst_n(rst_n), .acc_i(acc), .wr_i(wr_s), .oper_i(oper),
      .abank_i(abank), .w_i(wv), .wdata_i(wdata), .bsel_we_i(bwe),
      .bsel_d_i(bsel), .ldptr_i(ldp), .ldptr_sel_i(lsel), .ldptr_val_i(lval),
      .addr_o(addr_o), .null_o(null_o), .sfr_hit_o(sfr_hit_o),
      .sfr_rdata_o(sfr_rdata_o), .ptr_o(ptr_o)
   );

   // bench model, built from the requirements
   logic [11:0] mp [3];
   logic [3:0]  mb;

   typedef struct {
      string       tag;
      logic [11:0] a;
      logic        n;
      logic        h;
      logic [7:0]  rd;
   } sb_t;
   sb_t sbq [$];

   function automatic logic [11:0] dir_addr(input [7:0] op, input ab);
      if (ab) return op[7] ? {4'hF, op} : {4'h0, op};
      return {mb, op};
   endfunction

   function automatic logic in_vwin(input [11:0] a);
      logic r = 1'b0;
      for (int k = 0; k < 3; k++)
         if (a <= 12'hFEF - 12'(8*k) && a >= 12'hFEB - 12'(8*k)) r = 1'b1;
      return r;
   endfunction

   function automatic sb_t predict(input string tag, input [7:0] op, input ab, input [7:0] w);
      sb_t it;
      logic [11:0] d, base;
      d = dir_addr(op, ab);
      it.tag = tag; it.a = d; it.n = 1'b0; it.h = 1'b0; it.rd = 8'h00;
      for (int k = 0; k < 3; k++) begin
         base = 12'hFEF - 12'(8*k);
         if (d <= base && d >= base - 12'd4) begin
            case (base - d)
               12'd3:   it.a = mp[k] + 12'd1;
               12'd4:   it.a = mp[k] + {{4{w[7]}}, w};
               default: it.a = mp[k];
            endcase
            it.n = in_vwin(it.a);
         end
         if (d == base - 12'd5) begin it.h = 1'b1; it.rd = {4'h0, mp[k][11:8]}; end
         if (d == base - 12'd6) begin it.h = 1'b1; it.rd = mp[k][7:0]; end
      end
      return it;
   endfunction

   task automatic model_update(input [7:0] op, input ab, input wr, input [7:0] wd);
      logic [11:0] d, base;
      d = dir_addr(op, ab);
      for (int k = 0; k < 3; k++) begin
         base = 12'hFEF - 12'(8*k);
         if (d == base - 12'd1 || d == base - 12'd3) mp[k] = mp[k] + 12'd1;
         if (d == base - 12'd2) mp[k] = mp[k] - 12'd1;
         if (wr && d == base - 12'd5) mp[k] = {wd[3:0], mp[k][7:0]};
         if (wr && d == base - 12'd6) mp[k] = {mp[k][11:8], wd};
      end
   endtask

   // driver: one strobed access, expected result pushed to the scoreboard
   task automatic access(input string tag, input [7:0] op, input ab, input wr,
                         input [7:0] wd, input [7:0] w,
                         input ld = 1'b0, input [1:0] ls = 2'd0, input [11:0] lv = 12'h000);
      @(negedge clk);
      oper = op; abank = ab; wr_s = wr; wdata = wd; wv = w; acc = 1'b1;
      ldp = ld; lsel = ls; lval = lv;
      sbq.push_back(predict(tag, op, ab, w));
      @(negedge clk);
      acc = 1'b0; wr_s = 1'b0; ldp = 1'b0;
      model_update(op, ab, wr, wd);
      if (ld) mp[ls] = lv;
   endtask

   task automatic load_ptr(input [1:0] s, input [11:0] v);
      @(negedge clk); ldp = 1'b1; lsel = s; lval = v;
      @(negedge clk); ldp = 1'b0; mp[s] = v;
   endtask

   task automatic set_bank(input [3:0] b);
      @(negedge clk); bwe = 1'b1; bsel = b;
      @(negedge clk); bwe = 1'b0; mb = b;
   endtask

   task automatic chk_ptrs(input string tag);
      @(negedge clk); #3;
      for (int k = 0; k < 3; k++) begin
         checks++;
         if (ptr_o[k*12 +: 12] !== mp[k]) begin
            fails++;
            $display("FAIL %s pointer %0d: actual=%h expected=%h", tag, k, ptr_o[k*12 +: 12], mp[k]);
         end
      end
   endtask

   // monitor: pops expected items while the access is on the pins
   initial begin
      sb_t it;
      forever begin
         @(negedge clk); #2;
         if (sbq.size() > 0) begin
            it = sbq.pop_front();
            checks++;
            if (addr_o !== it.a || null_o !== it.n || sfr_hit_o !== it.h || sfr_rdata_o !== it.rd) begin
               fails++;
               $display("FAIL %s: actual addr=%h null=%b hit=%b rd=%h expected addr=%h null=%b hit=%b rd=%h",
                        it.tag, addr_o, null_o, sfr_hit_o, sfr_rdata_o, it.a, it.n, it.h, it.rd);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 3; k++) mp[k] = 12'h000;
      mb = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      chk_ptrs("R1 reset pointers");
      access("R1 reset bank", 8'h34, 1'b0, 1'b0, 8'h00, 8'h00);

      access("R2 window low 12", 8'h12, 1'b1, 1'b0, 8'h00, 8'h00);
      access("R2 window low 7F", 8'h7F, 1'b1, 1'b0, 8'h00, 8'h00);
      access("R2 window high 80", 8'h80, 1'b1, 1'b0, 8'h00, 8'h00);
      access("R2 window high E8", 8'hE8, 1'b1, 1'b0, 8'h00, 8'h00);

      set_bank(4'h1);
      access("R3 bank 1", 8'h23, 1'b0, 1'b0, 8'h00, 8'h00);
      set_bank(4'hE);
      access("R3 bank E", 8'hFF, 1'b0, 1'b0, 8'h00, 8'h00);
      set_bank(4'hF);
      access("R3 bank F", 8'h08, 1'b0, 1'b0, 8'h00, 8'h00);

      load_ptr(2'd0, 12'h100);
      load_ptr(2'd1, 12'h200);
      load_ptr(2'd2, 12'hFFF);
      chk_ptrs("R8 load");

      access("R4 plain ptr0", 8'hEF, 1'b1, 1'b0, 8'h00, 8'h00);
      access("R4 plain ptr2", 8'hDF, 1'b1, 1'b0, 8'h00, 8'h00);
      chk_ptrs("R4 plain unchanged");

      access("R5 postinc ptr1", 8'hE6, 1'b1, 1'b0, 8'h00, 8'h00);
      access("R5 postdec ptr0", 8'hED, 1'b1, 1'b0, 8'h00, 8'h00);
      access("R5 postinc ptr2 wrap", 8'hDE, 1'b1, 1'b0, 8'h00, 8'h00);
      chk_ptrs("R5 after steps");
      access("R5 postdec ptr2 wrap", 8'hDD, 1'b1, 1'b0, 8'h00, 8'h00);
      chk_ptrs("R5 wrap down");

      access("R6 preinc ptr0", 8'hEC, 1'b1, 1'b0, 8'h00, 8'h00);
      access("R6 preinc ptr2 wrap", 8'hDC, 1'b1, 1'b0, 8'h00, 8'h00);
      chk_ptrs("R6 after preinc");

      load_ptr(2'd0, 12'h050);
      access("R7 plusW +16", 8'hEB, 1'b1, 1'b0, 8'h00, 8'h10);
      access("R7 plusW -128 wrap", 8'hEB, 1'b1, 1'b0, 8'h00, 8'h80);
      access("R7 plusW -1 banked", 8'hEB, 1'b0, 1'b0, 8'h00, 8'hFF);
      chk_ptrs("R7 unchanged");

      access("R9 write high ptr0", 8'hEA, 1'b1, 1'b1, 8'h3C, 8'h00);
      access("R9 read high ptr0", 8'hEA, 1'b1, 1'b0, 8'h00, 8'h00);
      access("R9 write low ptr0", 8'hE9, 1'b1, 1'b1, 8'h5A, 8'h00);
      access("R9 read low ptr0 banked", 8'hE9, 1'b0, 1'b0, 8'h00, 8'h00);
      access("R9 read high ptr1", 8'hE2, 1'b1, 1'b0, 8'h00, 8'h00);
      chk_ptrs("R9 halves");

      @(negedge clk);
      oper = 8'hEE; abank = 1'b1; wr_s = 1'b1; wdata = 8'h77; acc = 1'b0;
      repeat (3) @(negedge clk);
      oper = 8'hE9;
      repeat (2) @(negedge clk);
      wr_s = 1'b0;
      chk_ptrs("R10 no strobe");

      load_ptr(2'd1, 12'hFEF);
      access("R11 nested plain", 8'hE7, 1'b1, 1'b0, 8'h00, 8'h00);
      access("R11 nested postinc", 8'hE6, 1'b1, 1'b1, 8'h99, 8'h00);
      chk_ptrs("R11 side effect");
      access("R11 out of window", 8'hE7, 1'b1, 1'b0, 8'h00, 8'h00);
      chk_ptrs("R11 no write to ptr0");

      access("R8 load beats postinc", 8'hEE, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 2'd0, 12'h321);
      chk_ptrs("R8 priority");

      repeat (2) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule